// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block buffers the transactions that cross a bus-to-bus bridge in one direction. Every entry carries one of five classes: posted memory write, delayed read request, delayed write request, delayed read completion and delayed write completion. Each cycle it offers the destination-side bus engine one entry to issue. The choice follows a class-based ordering rule, not plain first-in-first-out. Posted writes keep their arrival order. Requests can never overtake an earlier posted write. A posted write can overtake a request that was retried.

When the destination side finishes a delayed request, the entry becomes a completion in place and moves to the young end of the queue. It stays there until the originating master repeats the same request on the lookup port. The lookup then returns the status (and the data, for a read) and frees the slot. The same lookup port can drop a request that has never been attempted on the destination side. The bus state machines on either side sit outside this block.

Top module: `bridge_order_queue`

## Requirements
- R1: After reset the queue is empty: `iss_valid`=0, `enq_ready`=1, `lk_hit`=0 and `lk_dropped`=0.
- R2: An entry is stored when `enq_valid` and `enq_ready` are both high at a clock edge. `enq_ready` is low exactly when all DEPTH slots are occupied, whatever their classes. A posted write offered to a full queue is not stored and must be retried by its source. A posted write offered while requests are pending but a slot is free is stored.
- R3: Class codes on `enq_class` and `iss_class` are 0 posted write, 1 read request, 2 write request, 3 read completion, 4 write completion. Posted writes leave in arrival order. A posted write answered with `iss_retry` remains the next entry offered.
- R4: A read or write request is never offered while an older posted write is still held.
- R5: The entry offered is the oldest held entry of class 0, 1 or 2. Completions are never offered on the issue port.
- R6: When a request is answered with `iss_retry`, it is marked as attempted and becomes the youngest entry. A posted write that arrived after it is therefore offered before it is offered again.
- R7: When a request is answered with `iss_done`, it becomes a completion and becomes the youngest entry. A read becomes class 3 and stores `rsp_data` and `rsp_status`. A write becomes class 4 and stores `rsp_status`. `iss_done` takes precedence over `iss_retry`.
- R8: A lookup with `lk_drop`=0 hits when a completion of the right kind is held. The kind is class 3 when `lk_write`=0 and class 4 when `lk_write`=1, and the completion must have the same address and master ID and no older posted write in the queue. On a hit the lookup returns the status, and the data for a read (zero for a write). The entry is freed at the clock edge, so the same lookup afterwards misses.
- R9: A completion may be retired by lookup while older requests are still held.
- R10: A lookup with `lk_drop`=1 frees a matching request (class 1 when `lk_write`=0, class 2 when `lk_write`=1, same address and ID) that has never been attempted, and raises `lk_dropped`. A request already attempted is left untouched and is offered again.
- R11: A posted write answered with `iss_done` is freed at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New transaction offered |
| enq_class | input | 3 | Class of new transaction (0, 1 or 2) |
| enq_addr | input | AW | Address of new transaction |
| enq_data | input | DW | Write data of new transaction |
| enq_id | input | IDW | Originating master ID |
| enq_ready | output | 1 | A free slot exists |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_class | output | 3 | Class of offered entry |
| iss_addr | output | AW | Address of offered entry |
| iss_data | output | DW | Data of offered entry |
| iss_id | output | IDW | Master ID of offered entry |
| iss_done | input | 1 | Offered entry completed on destination |
| iss_retry | input | 1 | Offered entry was retried on destination |
| rsp_data | input | DW | Read data returned with `iss_done` |
| rsp_status | input | SW | Completion status returned with `iss_done` |
| lk_valid | input | 1 | Repeated request or drop presented |
| lk_write | input | 1 | 1 for a write, 0 for a read |
| lk_drop | input | 1 | 1 to drop an unattempted request |
| lk_addr | input | AW | Address of repeated request |
| lk_id | input | IDW | Master ID of repeated request |
| lk_hit | output | 1 | Completion found and retired |
| lk_data | output | DW | Read data of retired completion |
| lk_status | output | SW | Status of retired completion |
| lk_dropped | output | 1 | Unattempted request was dropped |

## Verification
The hardest state to reach is a completion that sits behind an older posted write. A request cannot reach the destination while a posted write is ahead of it, so the situation only arises through the move-to-back on completion. The stimulus enqueues a read request and then a posted write. It completes the request first, so the new completion lands behind the write. A repeated lookup must miss until that write is done. A second sequence retries one request and completes a later write request, so a write completion lies behind a pending read request and must still retire.

// File: rtl/bridge_oq_pkg.sv
package bridge_oq_pkg;

    typedef enum logic [2:0] {
        CLS_PMW = 3'd0,
        CLS_DRR = 3'd1,
        CLS_DWR = 3'd2,
        CLS_DRC = 3'd3,
        CLS_DWC = 3'd4
    } cls_e;

endpackage

// File: rtl/oq_older_pmw.sv
// Per-entry flag: some held posted write is older than this entry.
module oq_older_pmw #(
    parameter int DEPTH = 4,
    parameter int RW    = 2
) (
    input  logic [DEPTH-1:0]         is_pmw,
    input  logic [DEPTH-1:0][RW-1:0] rank,
    output logic [DEPTH-1:0]         blocked
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        logic b;
        always_comb begin
            b = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (is_pmw[j] && (rank[j] < rank[gi])) b = 1'b1;
            end
        end
        assign blocked[gi] = b;
    end
endmodule

// File: rtl/oq_pick_oldest.sv
// Selects the candidate with the lowest rank (ranks are unique).
module oq_pick_oldest #(
    parameter int DEPTH = 4,
    parameter int RW    = 2,
    parameter int IW    = 2
) (
    input  logic [DEPTH-1:0]         cand,
    input  logic [DEPTH-1:0][RW-1:0] rank,
    output logic                     found,
    output logic [IW-1:0]            idx
);
    logic [DEPTH-1:0] win;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            win[i] = cand[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (cand[j] && (rank[j] < rank[i])) win[i] = 1'b0;
            end
        end
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win[i]) idx = IW'(i);
        end
        found = |cand;
    end
endmodule

// File: rtl/oq_rerank.sv
// Recomputes age ranks: survivors keep relative order, the moved entry
// goes behind them, a newly written slot goes behind everything.
module oq_rerank #(
    parameter int DEPTH = 4,
    parameter int RW    = 2,
    parameter int CW    = 3
) (
    input  logic [DEPTH-1:0]         surv,
    input  logic [DEPTH-1:0]         mov,
    input  logic [DEPTH-1:0]         nslot,
    input  logic [DEPTH-1:0][RW-1:0] rank_q,
    output logic [DEPTH-1:0][RW-1:0] rank_d
);
    logic [CW-1:0] n_surv;
    logic [CW-1:0] n_stay;

    always_comb begin
        n_surv = '0;
        n_stay = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (surv[j]) n_surv = n_surv + 1'b1;
            if (surv[j] && !mov[j]) n_stay = n_stay + 1'b1;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rank
        logic [CW-1:0] ahead;
        always_comb begin
            ahead = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (surv[j] && !mov[j] && (rank_q[j] < rank_q[gi])) ahead = ahead + 1'b1;
            end
            if (nslot[gi])      rank_d[gi] = RW'(n_surv);
            else if (mov[gi])   rank_d[gi] = RW'(n_stay);
            else if (surv[gi])  rank_d[gi] = RW'(ahead);
            else                rank_d[gi] = rank_q[gi];
        end
    end
endmodule

// File: rtl/bridge_order_queue.sv
module bridge_order_queue
    import bridge_oq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IDW   = 4,
    parameter int SW    = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enq_valid,
    input  logic [2:0]     enq_class,
    input  logic [AW-1:0]  enq_addr,
    input  logic [DW-1:0]  enq_data,
    input  logic [IDW-1:0] enq_id,
    output logic           enq_ready,
    output logic           iss_valid,
    output logic [2:0]     iss_class,
    output logic [AW-1:0]  iss_addr,
    output logic [DW-1:0]  iss_data,
    output logic [IDW-1:0] iss_id,
    input  logic           iss_done,
    input  logic           iss_retry,
    input  logic [DW-1:0]  rsp_data,
    input  logic [SW-1:0]  rsp_status,
    input  logic           lk_valid,
    input  logic           lk_write,
    input  logic           lk_drop,
    input  logic [AW-1:0]  lk_addr,
    input  logic [IDW-1:0] lk_id,
    output logic           lk_hit,
    output logic [DW-1:0]  lk_data,
    output logic [SW-1:0]  lk_status,
    output logic           lk_dropped
);
    localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IW = RW;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]          vld;
        logic [DEPTH-1:0]          tried;
        cls_e [DEPTH-1:0]          cls;
        logic [DEPTH-1:0][RW-1:0]  rank;
        logic [DEPTH-1:0][AW-1:0]  addr;
        logic [DEPTH-1:0][DW-1:0]  data;
        logic [DEPTH-1:0][IDW-1:0] id;
        logic [DEPTH-1:0][SW-1:0]  sts;
    } st_t;

    st_t st_q, st_d;

    logic [DEPTH-1:0]         is_pmw, iss_cand, lk_cand, drop_cand, older_pmw;
    logic [DEPTH-1:0]         free_m, mov_m, surv_m, nslot_m;
    logic [DEPTH-1:0][RW-1:0] rank_nx;
    logic                     iss_found, lk_found, drop_found;
    logic [IW-1:0]            iss_idx, lk_idx, drop_idx, free_idx;
    logic                     full, enq_fire, hs, fire_done, iss_is_req;
    logic [CW-1:0]            occ_q;
    cls_e                     lk_cmp_cls, lk_req_cls;

    // ---- candidate masks ----
    always_comb begin
        lk_cmp_cls = lk_write ? CLS_DWC : CLS_DRC;
        occ_q      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            is_pmw[i]   = st_q.vld[i] && (st_q.cls[i] == CLS_PMW);
            iss_cand[i] = st_q.vld[i] && ((st_q.cls[i] == CLS_PMW) ||
                          (st_q.cls[i] == CLS_DRR) || (st_q.cls[i] == CLS_DWR));
            lk_cand[i]  = st_q.vld[i] && (st_q.cls[i] == lk_cmp_cls) &&
                          (st_q.addr[i] == lk_addr) && (st_q.id[i] == lk_id) &&
                          !older_pmw[i];
            if (st_q.vld[i]) occ_q = occ_q + 1'b1;
        end
    end

    oq_older_pmw #(.DEPTH(DEPTH), .RW(RW)) u_older (
        .is_pmw (is_pmw),
        .rank   (st_q.rank),
        .blocked(older_pmw)
    );

    oq_pick_oldest #(.DEPTH(DEPTH), .RW(RW), .IW(IW)) u_pick_iss (
        .cand (iss_cand),
        .rank (st_q.rank),
        .found(iss_found),
        .idx  (iss_idx)
    );

    oq_pick_oldest #(.DEPTH(DEPTH), .RW(RW), .IW(IW)) u_pick_lk (
        .cand (lk_cand),
        .rank (st_q.rank),
        .found(lk_found),
        .idx  (lk_idx)
    );

    // ---- handshake and drop candidates ----
    always_comb begin
        hs         = iss_found && (iss_done || iss_retry);
        fire_done  = iss_found && iss_done;
        iss_is_req = (st_q.cls[iss_idx] == CLS_DRR) || (st_q.cls[iss_idx] == CLS_DWR);
        lk_req_cls = lk_write ? CLS_DWR : CLS_DRR;
        for (int i = 0; i < DEPTH; i++) begin
            drop_cand[i] = st_q.vld[i] && (st_q.cls[i] == lk_req_cls) && !st_q.tried[i] &&
                           (st_q.addr[i] == lk_addr) && (st_q.id[i] == lk_id) &&
                           !(hs && (iss_idx == IW'(i)));
        end
    end

    oq_pick_oldest #(.DEPTH(DEPTH), .RW(RW), .IW(IW)) u_pick_drop (
        .cand (drop_cand),
        .rank (st_q.rank),
        .found(drop_found),
        .idx  (drop_idx)
    );

    // ---- outputs ----
    always_comb begin
        full       = &st_q.vld;
        enq_ready  = !full;
        enq_fire   = enq_valid && !full;
        iss_valid  = iss_found;
        iss_class  = st_q.cls[iss_idx];
        iss_addr   = st_q.addr[iss_idx];
        iss_data   = st_q.data[iss_idx];
        iss_id     = st_q.id[iss_idx];
        lk_hit     = lk_valid && !lk_drop && lk_found;
        lk_dropped = lk_valid && lk_drop && drop_found;
        lk_data    = (lk_hit && (st_q.cls[lk_idx] == CLS_DRC)) ? st_q.data[lk_idx] : '0;
        lk_status  = lk_hit ? st_q.sts[lk_idx] : '0;
    end

    // ---- slot bookkeeping ----
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) free_idx = IW'(i);
        end
        free_m  = '0;
        mov_m   = '0;
        nslot_m = '0;
        if (lk_hit)                   free_m[lk_idx]   = 1'b1;
        if (lk_dropped)               free_m[drop_idx] = 1'b1;
        if (fire_done && !iss_is_req) free_m[iss_idx]  = 1'b1;
        if (hs && iss_is_req)         mov_m[iss_idx]   = 1'b1;
        if (enq_fire)                 nslot_m[free_idx] = 1'b1;
        surv_m = st_q.vld & ~free_m;
    end

    oq_rerank #(.DEPTH(DEPTH), .RW(RW), .CW(CW)) u_rerank (
        .surv  (surv_m),
        .mov   (mov_m),
        .nslot (nslot_m),
        .rank_q(st_q.rank),
        .rank_d(rank_nx)
    );

    // ---- next state ----
    always_comb begin
        st_d      = st_q;
        st_d.vld  = surv_m | nslot_m;
        st_d.rank = rank_nx;
        if (hs) st_d.tried[iss_idx] = 1'b1;
        if (fire_done && iss_is_req) begin
            st_d.sts[iss_idx] = rsp_status;
            if (st_q.cls[iss_idx] == CLS_DRR) begin
                st_d.cls[iss_idx]  = CLS_DRC;
                st_d.data[iss_idx] = rsp_data;
            end else begin
                st_d.cls[iss_idx]  = CLS_DWC;
            end
        end
        if (enq_fire) begin
            st_d.cls[free_idx]   = cls_e'(enq_class);
            st_d.addr[free_idx]  = enq_addr;
            st_d.data[free_idx]  = enq_data;
            st_d.id[free_idx]    = enq_id;
            st_d.sts[free_idx]   = '0;
            st_d.tried[free_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---- assertions ----
    a_r3_pmw_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 3'd0) |-> !older_pmw[iss_idx]);

    a_r4_req_behind_pmw: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_class == 3'd1 || iss_class == 3'd2)) |-> !older_pmw[iss_idx]);

    a_r5_no_completion_issue: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_class <= 3'd2));

    a_r2_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_ready) |=> (occ_q <= $past(occ_q)));

    a_r8_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !enq_fire) |=> (occ_q < $past(occ_q)));

    a_r10_drop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dropped |-> !lk_hit);

endmodule

// File: tb/bridge_order_queue_bench.sv
module bridge_order_queue_bench;
    localparam int AW = 16, DW = 16, IDW = 4, SW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enq_valid = 1'b0;
    logic [2:0]     enq_class = '0;
    logic [AW-1:0]  enq_addr = '0;
    logic [DW-1:0]  enq_data = '0;
    logic [IDW-1:0] enq_id = '0;
    logic           enq_ready;
    logic           iss_valid;
    logic [2:0]     iss_class;
    logic [AW-1:0]  iss_addr;
    logic [DW-1:0]  iss_data;
    logic [IDW-1:0] iss_id;
    logic           iss_done = 1'b0, iss_retry = 1'b0;
    logic [DW-1:0]  rsp_data = '0;
    logic [SW-1:0]  rsp_status = '0;
    logic           lk_valid = 1'b0, lk_write = 1'b0, lk_drop = 1'b0;
    logic [AW-1:0]  lk_addr = '0;
    logic [IDW-1:0] lk_id = '0;
    logic           lk_hit, lk_dropped;
    logic [DW-1:0]  lk_data;
    logic [SW-1:0]  lk_status;

    int checks = 0;
    int errors = 0;

    typedef struct { int cls; int addr; string tag; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    bridge_order_queue #(.DEPTH(4), .AW(AW), .DW(DW), .IDW(IDW), .SW(SW)) u_bridge_order_queue (
        .clk, .rst_n, .enq_valid, .enq_class, .enq_addr, .enq_data, .enq_id, .enq_ready,
        .iss_valid, .iss_class, .iss_addr, .iss_data, .iss_id, .iss_done, .iss_retry,
        .rsp_data, .rsp_status, .lk_valid, .lk_write, .lk_drop, .lk_addr, .lk_id,
        .lk_hit, .lk_data, .lk_status, .lk_dropped
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic enq(input int cls, input int addr, input int id);
        @(negedge clk);
        enq_valid = 1'b1; enq_class = 3'(cls); enq_addr = AW'(addr);
        enq_data = DW'(addr + 16'h100); enq_id = IDW'(id);
        @(posedge clk); #1;
        enq_valid = 1'b0;
    endtask

    // driver side of the scoreboard
    task automatic expect_iss(input int cls, input int addr, input string tag);
        exp_t e;
        e.cls = cls; e.addr = addr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor side: compare offered entry against expectation, then respond
    task automatic serve(input bit done, input int data, input int sts);
        exp_t e;
        @(negedge clk); #1;
        e = exp_q.pop_front();
        chk(iss_valid == 1'b1, e.tag, "iss_valid", int'(iss_valid), 1);
        chk(int'(iss_class) == e.cls, e.tag, "iss_class", int'(iss_class), e.cls);
        chk(int'(iss_addr) == e.addr, e.tag, "iss_addr", int'(iss_addr), e.addr);
        iss_done = done; iss_retry = !done;
        rsp_data = DW'(data); rsp_status = SW'(sts);
        @(posedge clk); #1;
        iss_done = 1'b0; iss_retry = 1'b0;
    endtask

    task automatic lookup(input bit wr, input bit drop, input int addr, input int id,
                          input bit e_hit, input int e_data, input int e_sts,
                          input bit e_drop, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_drop = drop; lk_addr = AW'(addr); lk_id = IDW'(id);
        #1;
        chk(lk_hit == e_hit, tag, "lk_hit", int'(lk_hit), int'(e_hit));
        chk(lk_dropped == e_drop, tag, "lk_dropped", int'(lk_dropped), int'(e_drop));
        if (e_hit) begin
            chk(int'(lk_data) == e_data, tag, "lk_data", int'(lk_data), e_data);
            chk(int'(lk_status) == e_sts, tag, "lk_status", int'(lk_status), e_sts);
        end
        @(posedge clk); #1;
        lk_valid = 1'b0; lk_drop = 1'b0;
    endtask

    task automatic idle(input string tag);
        @(negedge clk); #1;
        chk(iss_valid == 1'b0, tag, "iss_valid idle", int'(iss_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(iss_valid == 1'b0, "R1", "iss_valid", int'(iss_valid), 0);
        chk(enq_ready == 1'b1, "R1", "enq_ready", int'(enq_ready), 1);
        chk(lk_hit == 1'b0 && lk_dropped == 1'b0, "R1", "lookup outs", int'(lk_hit), 0);

        // R3, R11: posted writes in order, retry keeps position
        enq(0, 'h10, 1); enq(0, 'h11, 1); enq(0, 'h12, 1);
        expect_iss(0, 'h10, "R3"); serve(0, 0, 0);
        expect_iss(0, 'h10, "R3"); serve(1, 0, 0);
        expect_iss(0, 'h11, "R3"); serve(1, 0, 0);
        expect_iss(0, 'h12, "R11"); serve(1, 0, 0);
        idle("R11");

        // R4, R7, R8: request after write, then completion retired
        enq(0, 'h20, 1); enq(1, 'h21, 1);
        expect_iss(0, 'h20, "R4"); serve(0, 0, 0);
        expect_iss(0, 'h20, "R4"); serve(1, 0, 0);
        expect_iss(1, 'h21, "R7"); serve(1, 'hBEEF, 1);
        idle("R5");
        lookup(0, 0, 'h21, 1, 1, 'hBEEF, 1, 0, "R8");
        lookup(0, 0, 'h21, 1, 0, 0, 0, 0, "R8");

        // R6: retried request lets a younger write go first
        enq(1, 'h30, 2); enq(0, 'h31, 2);
        expect_iss(1, 'h30, "R6"); serve(0, 0, 0);
        expect_iss(0, 'h31, "R6"); serve(1, 0, 0);
        expect_iss(1, 'h30, "R6"); serve(1, 'h1234, 0);
        lookup(0, 0, 'h30, 2, 1, 'h1234, 0, 0, "R6");

        // R8: completion blocked by older posted write
        enq(1, 'h40, 3); enq(0, 'h41, 3);
        expect_iss(1, 'h40, "R7"); serve(1, 'h5555, 2);
        lookup(0, 0, 'h40, 3, 0, 0, 0, 0, "R8");
        expect_iss(0, 'h41, "R5"); serve(1, 0, 0);
        lookup(0, 0, 'h40, 3, 1, 'h5555, 2, 0, "R8");

        // R9: write completion passes older read request
        enq(1, 'h50, 4); enq(2, 'h51, 4);
        expect_iss(1, 'h50, "R9"); serve(0, 0, 0);
        expect_iss(2, 'h51, "R9"); serve(1, 0, 1);
        lookup(0, 0, 'h51, 4, 0, 0, 0, 0, "R8");
        lookup(1, 0, 'h51, 4, 1, 0, 1, 0, "R9");
        lookup(0, 0, 'h50, 5, 0, 0, 0, 0, "R8");
        expect_iss(1, 'h50, "R9"); serve(1, 'h7777, 3);
        lookup(0, 0, 'h50, 4, 1, 'h7777, 3, 0, "R9");

        // R10: drop only unattempted requests
        enq(1, 'h60, 6);
        lookup(0, 1, 'h60, 6, 0, 0, 0, 1, "R10");
        idle("R10");
        enq(1, 'h61, 6);
        expect_iss(1, 'h61, "R10"); serve(0, 0, 0);
        lookup(0, 1, 'h61, 6, 0, 0, 0, 0, "R10");
        expect_iss(1, 'h61, "R10"); serve(1, 'h0009, 0);
        lookup(0, 0, 'h61, 6, 1, 'h0009, 0, 0, "R10");

        // R2: full queue rejects a posted write
        enq(0, 'h70, 1); enq(0, 'h71, 1); enq(0, 'h72, 1); enq(0, 'h73, 1);
        @(negedge clk); #1;
        chk(enq_ready == 1'b0, "R2", "enq_ready full", int'(enq_ready), 0);
        enq(0, 'h74, 1);
        expect_iss(0, 'h70, "R2"); serve(1, 0, 0);
        @(negedge clk); #1;
        chk(enq_ready == 1'b1, "R2", "enq_ready after free", int'(enq_ready), 1);
        expect_iss(0, 'h71, "R2"); serve(1, 0, 0);
        expect_iss(0, 'h72, "R2"); serve(1, 0, 0);
        expect_iss(0, 'h73, "R2"); serve(1, 0, 0);
        idle("R2");

        // R2, R6: posted write accepted behind pending requests
        enq(1, 'h80, 7); enq(2, 'h81, 7); enq(1, 'h82, 7);
        @(negedge clk); #1;
        chk(enq_ready == 1'b1, "R2", "enq_ready with requests", int'(enq_ready), 1);
        enq(0, 'h83, 7);
        expect_iss(1, 'h80, "R6"); serve(0, 0, 0);
        expect_iss(2, 'h81, "R6"); serve(0, 0, 0);
        expect_iss(1, 'h82, "R6"); serve(0, 0, 0);
        expect_iss(0, 'h83, "R2"); serve(1, 0, 0);
        expect_iss(1, 'h80, "R6"); serve(1, 'h0A0A, 1);
        expect_iss(2, 'h81, "R6"); serve(1, 0, 2);
        expect_iss(1, 'h82, "R6"); serve(1, 'h0B0B, 3);
        idle("R5");
        lookup(1, 0, 'h81, 7, 1, 0, 2, 0, "R9");
        lookup(0, 0, 'h82, 7, 1, 'h0B0B, 3, 0, "R8");
        lookup(0, 0, 'h80, 7, 1, 'h0A0A, 1, 0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule